// File: doc/BRIEF.md
# Location-Bound ECC Cache Banks

This block holds the two storage arrays of a cache, one for data words and one for tags, and ties every stored word to the place it was written. On a write, a SECDED check code is computed over the payload. An address-derived tweak is then XORed into the whole code word, and the result is stored. On a read, the same kind of tweak is built from the read request and XORed out of the stored word before the code is checked. A word that comes back from a row other than the one the request meant does not decode cleanly, so the fault is reported as an ECC error.

For the data array, the tweak is the access address with the cache-line offset removed. For the tag array, the tweak is the tag index itself. The tweak source is zero-extended to the code-word width, or truncated to its low bits if it is wider. Errors are only detected, never corrected. A detected error on either array raises a single minor alert pin in the same cycle as the failing response. The cache controller that drives refills and replacement sits outside this block.

Each array has a request channel and a response channel. The request channel is qualified by a valid bit, and there is no ready: a request is accepted in every cycle in which valid is high. A read response appears exactly one cycle later and cannot be stalled, so the consumer must take it in that cycle. A write produces no response. The data address is a word address. A line holds 2^LINE_W bytes, so the tweak is the word address shifted right by LINE_W minus log2(DATA_W/8).

Top module: `tweak_ecc_banks`

## Requirements
- R1: A word written to a location and later read with the same address (data array) or index (tag array) returns the written payload with its error flag low.
- R2: A read request accepted at a clock edge gives a response valid in the next cycle. Write cycles and idle cycles give no response in the next cycle.
- R3: The data array row is the low DROW_W bits of the word address. The data tweak is the word address shifted right by LINE_W - log2(DATA_W/8), placed in the low bits of the code word. Writes to one row leave every other row's contents unchanged.
- R4: When a data row is read through an address whose tweak differs from the write tweak in one, two or three bits, the response error flag is high.
- R5: Tweak differences that produce a single-error syndrome (an odd number of flipped bits) and those that produce a double-error syndrome (an even number) are both reported as errors.
- R6: alert_minor_o is high exactly in a cycle in which a valid response of either array carries its error flag. Without a response it is low.
- R7: The tag array row and tweak are both the tag index. Each of the 2^SET_W indices holds its own tag independently.
- R8: While reset is asserted and right after it, neither response valid nor the alert is high.
- R9: The two arrays work independently in the same cycle: an error on one does not set the error flag or alter the payload of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dreq_valid_i | input | 1 | Data array request valid |
| dreq_write_i | input | 1 | 1 = write, 0 = read |
| dreq_addr_i | input | WADDR_W | Data word address |
| dreq_wdata_i | input | DATA_W | Data payload to write |
| drsp_valid_o | output | 1 | Data read response valid |
| drsp_data_o | output | DATA_W | Data payload read back (uncorrected) |
| drsp_err_o | output | 1 | ECC error on data response |
| treq_valid_i | input | 1 | Tag array request valid |
| treq_write_i | input | 1 | 1 = write, 0 = read |
| treq_idx_i | input | SET_W | Tag index |
| treq_wtag_i | input | TAG_W | Tag payload to write |
| trsp_valid_o | output | 1 | Tag read response valid |
| trsp_tag_o | output | TAG_W | Tag payload read back (uncorrected) |
| trsp_err_o | output | 1 | ECC error on tag response |
| alert_minor_o | output | 1 | Minor alert, high in a cycle with a flagged response |

## Verification
The bench runs on a small configuration: 8-bit data, 8 rows, 8-bit word addresses and 4-byte lines. Every payload value is swept through one location to show a clean round trip for all code words. Every data row is then written from every possible upper address and read back through all of its aliases. Aliases one bit away from the write tweak show single-syndrome detection. Aliases two bits away show double-syndrome detection, and aliases three bits away confirm detection at the code's distance limit. The read through the original address separates a correct tweak from a wrong one. The tag array is swept over all indices and all tag values. Finally, reads that collide on both arrays in the same cycle show which array owns an error and whether it reaches the alert.

// File: rtl/tweak_ecc_pkg.sv
package tweak_ecc_pkg;

  localparam int unsigned MAXK = 256;

  // Number of Hamming check bits for k payload bits (overall parity excluded).
  function automatic int unsigned ecc_r(int unsigned k);
    int unsigned r;
    r = 1;
    while ((1 << r) < (k + r + 1)) r++;
    return r;
  endfunction

  // Hamming position of payload bit i: the i-th integer above 2 that is not a power of two.
  function automatic int unsigned hpos(int unsigned i);
    int unsigned p;
    p = 2;
    for (int unsigned n = 0; n <= i; n++) begin
      p++;
      while ((p & (p - 1)) == 0) p++;
    end
    return p;
  endfunction

  // Payload bits that feed check bit j.
  function automatic logic [MAXK-1:0] col_mask(int unsigned k, int unsigned j);
    logic [MAXK-1:0] m;
    int unsigned p;
    m = '0;
    for (int unsigned i = 0; i < k; i++) begin
      p = hpos(i);
      m[i] = ((p >> j) & 1) != 0;
    end
    return m;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import tweak_ecc_pkg::*;
#(
  parameter int unsigned K = 32,
  localparam int unsigned R = ecc_r(K),
  localparam int unsigned N = K + R + 1
) (
  input  logic [K-1:0] data_i,
  output logic [N-1:0] code_o
);

  logic [R-1:0] chk;

  for (genvar j = 0; j < R; j++) begin : g_chk
    localparam logic [MAXK-1:0] MW = col_mask(K, j);
    assign chk[j] = ^(data_i & MW[K-1:0]);
  end

  // Layout: {overall parity, check bits, payload}
  assign code_o = {^{chk, data_i}, chk, data_i};

endmodule

// File: rtl/secded_chk.sv
module secded_chk
  import tweak_ecc_pkg::*;
#(
  parameter int unsigned K = 32,
  localparam int unsigned R = ecc_r(K),
  localparam int unsigned N = K + R + 1
) (
  input  logic [N-1:0] code_i,
  output logic [K-1:0] data_o,
  output logic         err_o
);

  logic [R-1:0] syn;
  logic         par_odd;

  assign data_o = code_i[K-1:0];

  for (genvar j = 0; j < R; j++) begin : g_syn
    localparam logic [MAXK-1:0] MW = col_mask(K, j);
    assign syn[j] = code_i[K+j] ^ (^(code_i[K-1:0] & MW[K-1:0]));
  end

  assign par_odd = ^code_i;

  // Single (odd parity) and double (even parity, nonzero syndrome) both count.
  assign err_o = (|syn) | par_odd;

endmodule

// File: rtl/tweak_bank.sv
module tweak_bank
  import tweak_ecc_pkg::*;
#(
  parameter int unsigned PAY_W = 32,
  parameter int unsigned ROW_W = 8,
  parameter int unsigned TWK_W = 8,
  localparam int unsigned N    = PAY_W + ecc_r(PAY_W) + 1,
  localparam int unsigned ROWS = 1 << ROW_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [TWK_W-1:0] req_tweak_i,
  input  logic [PAY_W-1:0] req_wdata_i,
  output logic             rsp_valid_o,
  output logic [PAY_W-1:0] rsp_data_o,
  output logic             rsp_err_o
);

  logic [N-1:0] twk_fit;
  logic [N-1:0] enc_word;
  logic [N-1:0] mem [ROWS];
  logic [N-1:0] rd_q;
  logic [N-1:0] twk_q;
  logic         rvalid_q;
  logic         chk_err;
  logic         do_wr;
  logic         do_rd;

  if (TWK_W >= N) begin : g_trunc
    assign twk_fit = req_tweak_i[N-1:0];
  end else begin : g_ext
    assign twk_fit = {{(N - TWK_W){1'b0}}, req_tweak_i};
  end

  assign do_wr = req_valid_i & req_write_i;
  assign do_rd = req_valid_i & ~req_write_i;

  secded_enc #(.K(PAY_W)) u_enc (
    .data_i (req_wdata_i),
    .code_o (enc_word)
  );

  // Storage array: no reset, one-cycle read.
  always_ff @(posedge clk_i) begin
    if (do_wr) mem[req_row_i] <= enc_word ^ twk_fit;
    if (do_rd) begin
      rd_q  <= mem[req_row_i];
      twk_q <= twk_fit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_q <= 1'b0;
    else         rvalid_q <= do_rd;
  end

  secded_chk #(.K(PAY_W)) u_chk (
    .code_i (rd_q ^ twk_q),
    .data_o (rsp_data_o),
    .err_o  (chk_err)
  );

  assign rsp_valid_o = rvalid_q;
  assign rsp_err_o   = rvalid_q & chk_err;

  // R2: read answered in the next cycle
  assert_read_rsp_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);

  // R2: writes produce no response
  assert_write_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i) |=> !rsp_valid_o);

  // R6: no request, no error
  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_err_o);

  // R1: write immediately followed by a read of the same row and tweak decodes cleanly
  assert_roundtrip_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(req_valid_i && req_write_i, 2)
     && ($past(req_row_i) == $past(req_row_i, 2))
     && ($past(req_tweak_i) == $past(req_tweak_i, 2)))
    |-> (!rsp_err_o && (rsp_data_o == $past(req_wdata_i, 2))));

endmodule

// File: rtl/tweak_ecc_banks.sv
module tweak_ecc_banks #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned WADDR_W = 12,
  parameter int unsigned LINE_W  = 4,
  parameter int unsigned DROW_W  = 8,
  parameter int unsigned TAG_W   = 20,
  parameter int unsigned SET_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dreq_valid_i,
  input  logic               dreq_write_i,
  input  logic [WADDR_W-1:0] dreq_addr_i,
  input  logic [DATA_W-1:0]  dreq_wdata_i,
  output logic               drsp_valid_o,
  output logic [DATA_W-1:0]  drsp_data_o,
  output logic               drsp_err_o,
  input  logic               treq_valid_i,
  input  logic               treq_write_i,
  input  logic [SET_W-1:0]   treq_idx_i,
  input  logic [TAG_W-1:0]   treq_wtag_i,
  output logic               trsp_valid_o,
  output logic [TAG_W-1:0]   trsp_tag_o,
  output logic               trsp_err_o,
  output logic               alert_minor_o
);

  localparam int unsigned WOFF  = $clog2(DATA_W / 8);
  localparam int unsigned LSH   = LINE_W - WOFF;
  localparam int unsigned DTW_W = WADDR_W - LSH;

  logic [DTW_W-1:0]  d_tweak;
  logic [DROW_W-1:0] d_row;

  assign d_row   = dreq_addr_i[DROW_W-1:0];
  assign d_tweak = dreq_addr_i[WADDR_W-1:LSH];

  tweak_bank #(
    .PAY_W (DATA_W),
    .ROW_W (DROW_W),
    .TWK_W (DTW_W)
  ) u_dbank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (dreq_valid_i),
    .req_write_i (dreq_write_i),
    .req_row_i   (d_row),
    .req_tweak_i (d_tweak),
    .req_wdata_i (dreq_wdata_i),
    .rsp_valid_o (drsp_valid_o),
    .rsp_data_o  (drsp_data_o),
    .rsp_err_o   (drsp_err_o)
  );

  tweak_bank #(
    .PAY_W (TAG_W),
    .ROW_W (SET_W),
    .TWK_W (SET_W)
  ) u_tbank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (treq_valid_i),
    .req_write_i (treq_write_i),
    .req_row_i   (treq_idx_i),
    .req_tweak_i (treq_idx_i),
    .req_wdata_i (treq_wtag_i),
    .rsp_valid_o (trsp_valid_o),
    .rsp_data_o  (trsp_tag_o),
    .rsp_err_o   (trsp_err_o)
  );

  assign alert_minor_o = drsp_err_o | trsp_err_o;

  // R6: alert only with a flagged, valid response
  assert_alert_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_minor_o |-> ((drsp_valid_o && drsp_err_o) || (trsp_valid_o && trsp_err_o)));

  // R8: nothing is reported in the first cycle after reset
  assert_reset_quiet_R8: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!drsp_valid_o && !trsp_valid_o && !alert_minor_o));

endmodule

// File: tb/tweak_ecc_banks_test.sv
module tweak_ecc_banks_test;

  localparam int DW = 8;
  localparam int AW = 8;
  localparam int TW = 6;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dv = 1'b0, dwr = 1'b0;
  logic [AW-1:0] da = '0;
  logic [DW-1:0] dd = '0;
  logic          tv = 1'b0, twr = 1'b0;
  logic [SW-1:0] ti = '0;
  logic [TW-1:0] tt = '0;
  logic          drv, derr, trv, terr, alert;
  logic [DW-1:0] dq;
  logic [TW-1:0] tq;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tweak_ecc_banks #(
    .DATA_W (DW), .WADDR_W (AW), .LINE_W (2), .DROW_W (3),
    .TAG_W (TW), .SET_W (SW)
  ) uut (
    .clk_i (clk), .rst_ni (rst_n),
    .dreq_valid_i (dv), .dreq_write_i (dwr), .dreq_addr_i (da), .dreq_wdata_i (dd),
    .drsp_valid_o (drv), .drsp_data_o (dq), .drsp_err_o (derr),
    .treq_valid_i (tv), .treq_write_i (twr), .treq_idx_i (ti), .treq_wtag_i (tt),
    .trsp_valid_o (trv), .trsp_tag_o (tq), .trsp_err_o (terr),
    .alert_minor_o (alert)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle of requests; outputs of that cycle's reads are visible on return.
  task automatic step(input bit v_d, input bit w_d, input int a_d, input int d_d,
                      input bit v_t, input bit w_t, input int i_t, input int t_t);
    dv = v_d; dwr = w_d; da = AW'(a_d); dd = DW'(d_d);
    tv = v_t; twr = w_t; ti = SW'(i_t); tt = TW'(t_t);
    @(negedge clk);
    dv = 1'b0; tv = 1'b0;
  endtask

  task automatic dwrite(input int a, input int d);
    step(1, 1, a, d, 0, 0, 0, 0);
    check(drv == 1'b0, "R2", "no response after data write", drv, 0);
  endtask

  task automatic dread_ok(input int a, input int d, input string req);
    step(1, 0, a, 0, 0, 0, 0, 0);
    check(drv == 1'b1, "R2", "data response valid", drv, 1);
    check(derr == 1'b0 && dq == DW'(d), req, "clean data readback", {derr, dq}, d);
    check(alert == 1'b0, "R6", "alert on clean read", alert, 0);
  endtask

  function automatic int pat(input int a, input int k);
    return (a * 37 + k * 91 + 11) & 8'hff;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(drv == 0 && trv == 0 && alert == 0, "R8", "quiet during reset", {drv, trv, alert}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(drv == 0 && trv == 0 && alert == 0, "R8", "quiet after reset", {drv, trv, alert}, 0);

    // R1: every payload value round-trips through one location
    for (int v = 0; v < 256; v++) begin
      dwrite(8'h2d, v);
      dread_ok(8'h2d, v, "R1");
    end

    // R3/R4/R5: every row, every writing upper address, every alias
    for (int r = 0; r < 8; r++) begin
      for (int ub = 0; ub < 32; ub++) begin
        int a0 = (ub << 3) | r;
        dwrite(a0, pat(a0, 1));
        dread_ok(a0, pat(a0, 1), "R1");
        for (int u = 0; u < 32; u++) begin
          int w = $countones(u ^ ub);
          if (w >= 1 && w <= 3) begin
            step(1, 0, (u << 3) | r, 0, 0, 0, 0, 0);
            if (w == 1)      check(derr == 1'b1, "R5", "single-syndrome alias flagged", derr, 1);
            else if (w == 2) check(derr == 1'b1, "R5", "double-syndrome alias flagged", derr, 1);
            else             check(derr == 1'b1, "R4", "three-bit alias flagged", derr, 1);
            check(alert == 1'b1, "R6", "alert follows data error", alert, 1);
          end
        end
      end
    end

    // R3: rows are independent
    for (int r = 0; r < 8; r++) dwrite((r * 5 << 3) | r, pat(r, 2));
    for (int r = 0; r < 8; r++) dread_ok((r * 5 << 3) | r, pat(r, 2), "R3");

    // R7: tag array, all indices and all tag values
    for (int i = 0; i < 8; i++) begin
      for (int t = 0; t < 64; t++) begin
        step(0, 0, 0, 0, 1, 1, i, t);
        check(trv == 1'b0, "R2", "no response after tag write", trv, 0);
        step(0, 0, 0, 0, 1, 0, i, 0);
        check(trv == 1'b1 && terr == 1'b0 && tq == TW'(t), "R7", "tag readback", {trv, terr, tq}, 128 | t);
      end
    end
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 1, 1, i, (i * 7 + 3) & 63);
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 0, 0, 1, 0, i, 0);
      check(terr == 1'b0 && tq == TW'((i * 7 + 3) & 63), "R7", "tag index independence", tq, (i * 7 + 3) & 63);
    end

    // R9/R6: both arrays in one cycle
    dwrite(8'h13, 8'ha5);
    step(1, 0, 8'h1b, 0, 1, 0, 5, 0);   // data alias (one tweak bit off), tag correct
    check(derr == 1'b1, "R9", "data error while tag clean", derr, 1);
    check(terr == 1'b0 && tq == TW'((5 * 7 + 3) & 63), "R9", "tag unaffected by data error", tq, (5 * 7 + 3) & 63);
    check(alert == 1'b1, "R6", "alert with one array in error", alert, 1);
    step(1, 0, 8'h13, 0, 1, 0, 2, 0);
    check(derr == 0 && terr == 0 && dq == 8'ha5, "R9", "both arrays clean together", dq, 8'ha5);
    check(alert == 1'b0, "R6", "no alert when both clean", alert, 0);

    // R2/R6: idle cycle
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check(drv == 0 && trv == 0 && alert == 0, "R2", "idle cycle silent", {drv, trv, alert}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule